// File: doc/BRIEF.md
# Selectable Receive Stream Router

This block sits between twelve asynchronous serial receive lines and the twelve lines that leave the board. A 4-bit mode word decides how the lines are routed. In the default routing each line passes straight through to the output with the same index, with no clock in the path.

In the double-phase mode, only six inputs are used. Each is sampled by the local clock on its rising edge and on its falling edge, and the two samples form a pair of synchronous output streams. Six inputs therefore feed twelve outputs.

A host can freeze the current stream values into a snapshot register with a read strobe. It can also arm a capture memory that records a run of consecutive samples, which the host reads back at its own pace after a done flag rises.

Top module: `rx_stream_router`

## Requirements
- R1: With mode code 0, every output line follows the input line with the same index combinationally, without waiting for a clock edge.
- R2: With mode code 1 (double-phase mode), output 2*j for j = 0..5 takes the value that input 2+j held at the most recent rising clock edge, updated on that edge.
- R3: In double-phase mode, output 2*j+1 for j = 0..5 takes the value that input 2+j held at the falling clock edge just before the most recent rising edge.
- R4: In double-phase mode, inputs 0, 1 and 8 to 11 have no effect on any output.
- R5: While rst_n is low, the double-phase sample registers, the snapshot register and the capture done flag are all zero. In mode 1 the outputs therefore read all zero.
- R6: On a rising edge with snap_rd high in mode 1, snap_q loads the output value held just before that edge. Without snap_rd, snap_q keeps its value.
- R7: Outside mode 1, a snap_rd at rising edge e loads the input value present at edge e-2, which has passed through a two-stage synchroniser.
- R8: A cap_arm seen at rising edge a clears cap_done. The 32 following rising edges write capture entries 0 to 31 from the same source the snapshot uses. cap_done rises after the edge that writes entry 31. Outside mode 1, entry i therefore holds the input at edge a-1+i, and cap_rdata shows the entry addressed by cap_raddr.
- R9: The mode codes 2 to 15 route exactly as mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock. Its rising edge is phase 0 and its falling edge is phase 1. |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 4 | Routing mode: 1 selects double-phase, any other code selects pass-through |
| din | input | 12 | Asynchronous received lines |
| dout | output | 12 | Routed output lines |
| snap_rd | input | 1 | Host strobe that loads the snapshot register |
| snap_q | output | 12 | Snapshot register |
| cap_arm | input | 1 | Starts a new capture run |
| cap_done | output | 1 | High once all 32 entries have been written |
| cap_raddr | input | 5 | Capture read address |
| cap_rdata | output | 12 | Capture entry at cap_raddr |

## Verification
The hardest case to reach is the odd output of each pair. It depends on the falling-edge sample, so a bench that changes inputs only once per cycle cannot tell it apart from the even output. The stimulus therefore applies one input word before the falling edge and a second word before the rising edge, and the words differ on the sampled lines. Capture contents and the synchronised snapshot depend on exact edge counts. For that reason the bench drives a counting pattern that changes at every falling edge, so each captured entry identifies the edge at which it was taken.

// File: rtl/rx_stream_router.sv
module rx_stream_router #(
  parameter int LINES     = 12,
  parameter int MODE_W    = 4,
  parameter int PIX_BASE  = 2,
  parameter int PIX_CODE  = 1,
  parameter int CAP_DEPTH = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [MODE_W-1:0]             mode,
  input  logic [LINES-1:0]              din,
  output logic [LINES-1:0]              dout,
  input  logic                          snap_rd,
  output logic [LINES-1:0]              snap_q,
  input  logic                          cap_arm,
  output logic                          cap_done,
  input  logic [$clog2(CAP_DEPTH)-1:0]  cap_raddr,
  output logic [LINES-1:0]              cap_rdata
);
  localparam int PIX_N = LINES / 2;
  localparam int AW    = $clog2(CAP_DEPTH);

  logic             pix;
  logic [PIX_N-1:0] ph1_q;
  logic [LINES-1:0] pix_d, pix_q, sync1, sync2, src;
  logic             armed;
  logic [AW-1:0]    widx;
  logic [LINES-1:0] mem [CAP_DEPTH];

  assign pix = (mode == MODE_W'(PIX_CODE));

  always_ff @(negedge clk or negedge rst_n)
    if (!rst_n) ph1_q <= '0;
    else        ph1_q <= din[PIX_BASE +: PIX_N];

  always_comb
    for (int j = 0; j < PIX_N; j++) begin
      pix_d[2*j]   = din[PIX_BASE+j];
      pix_d[2*j+1] = ph1_q[j];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pix_q <= '0;
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      pix_q <= pix_d;
      sync1 <= din;
      sync2 <= sync1;
    end

  assign dout = pix ? pix_q : din;
  assign src  = pix ? pix_q : sync2;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       snap_q <= '0;
    else if (snap_rd) snap_q <= src;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      armed    <= 1'b0;
      widx     <= '0;
      cap_done <= 1'b0;
    end else if (cap_arm) begin
      armed    <= 1'b1;
      widx     <= '0;
      cap_done <= 1'b0;
    end else if (armed) begin
      widx <= widx + 1'b1;
      if (widx == AW'(CAP_DEPTH-1)) begin
        armed    <= 1'b0;
        cap_done <= 1'b1;
      end
    end

  always_ff @(posedge clk)
    if (armed && !cap_arm) mem[widx] <= src;

  assign cap_rdata = mem[cap_raddr];
endmodule

// File: rtl/rx_stream_router_chk.sv
module rx_stream_router_chk #(
  parameter int LINES    = 12,
  parameter int MODE_W   = 4,
  parameter int PIX_BASE = 2,
  parameter int PIX_CODE = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [MODE_W-1:0] mode,
  input logic [LINES-1:0]  din,
  input logic [LINES-1:0]  dout,
  input logic              snap_rd,
  input logic [LINES-1:0]  snap_q,
  input logic              cap_arm,
  input logic              cap_done
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;

  always_comb
    if (rst_n && mode != MODE_W'(PIX_CODE))
      AST_PASS_THROUGH: assert (dout == din); // R1

  always_comb
    if (!rst_n)
      AST_RESET_CLEAR: assert (snap_q == '0 && !cap_done); // R5

  generate
    for (genvar j = 0; j < LINES/2; j++) begin : g_even
      AST_PIX_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && mode == MODE_W'(PIX_CODE)) |-> dout[2*j] == $past(din[PIX_BASE+j])); // R2
    end
  endgenerate

  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && !snap_rd) |=> $stable(snap_q)); // R6

  AST_ARM_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_arm |=> !cap_done); // R8
endmodule

bind rx_stream_router rx_stream_router_chk #(
  .LINES(LINES), .MODE_W(MODE_W), .PIX_BASE(PIX_BASE), .PIX_CODE(PIX_CODE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .mode(mode), .din(din), .dout(dout),
  .snap_rd(snap_rd), .snap_q(snap_q), .cap_arm(cap_arm), .cap_done(cap_done)
);

// File: tb/rx_stream_router_tb_top.sv
module rx_stream_router_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  mode = 4'd0;
  logic [11:0] din = '0;
  logic [11:0] dout;
  logic        snap_rd = 1'b0;
  logic [11:0] snap_q;
  logic        cap_arm = 1'b0;
  logic        cap_done;
  logic [4:0]  cap_raddr = '0;
  logic [11:0] cap_rdata;
  int          tests = 0;
  int          fails = 0;
  bit          ended = 1'b0;

  always #4 clk = ~clk;

  rx_stream_router dut_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .din(din), .dout(dout),
    .snap_rd(snap_rd), .snap_q(snap_q), .cap_arm(cap_arm), .cap_done(cap_done),
    .cap_raddr(cap_raddr), .cap_rdata(cap_rdata)
  );

  // {word before falling edge, word before rising edge}
  localparam logic [23:0] PIX_VEC [8] = '{
    {12'h000, 12'h0FC}, {12'h0FC, 12'h000}, {12'h0A8, 12'h054},
    {12'h054, 12'h0A8}, {12'hF03, 12'h0FC}, {12'h0FC, 12'hF03},
    {12'h0CC, 12'h030}, {12'h3C3, 12'hC3C}
  };
  localparam logic [15:0] NRM_VEC [6] = '{
    {4'd0, 12'hA5A}, {4'd0, 12'h5A5}, {4'd2, 12'hFFF},
    {4'd7, 12'h001}, {4'd15, 12'h800}, {4'd0, 12'h3C6}
  };

  function automatic logic [11:0] pix_exp(logic [11:0] fall_w, logic [11:0] rise_w);
    logic [11:0] r;
    for (int j = 0; j < 6; j++) begin
      r[2*j]   = rise_w[2+j];
      r[2*j+1] = fall_w[2+j];
    end
    return r;
  endfunction

  function automatic logic [11:0] pat(int n);
    return 12'((n * 12'h0B7) ^ (n << 5) ^ 12'h3A1);
  endfunction

  task automatic chk(string req, logic [11:0] act, logic [11:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic pix_step(logic [11:0] a, logic [11:0] b);
    @(posedge clk); #1 din = a;
    @(negedge clk); #1 din = b;
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    tests++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    // R5: reset state in double-phase mode
    mode = 4'd1; din = 12'hFFF;
    repeat (3) @(posedge clk);
    #1;
    chk("R5 dout", dout, 12'h000);
    chk("R5 snap", snap_q, 12'h000);
    chk("R5 done", {11'd0, cap_done}, 12'h000);
    @(negedge clk); rst_n = 1'b1;

    // R1/R9: pass-through table
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      mode = NRM_VEC[i][15:12]; din = NRM_VEC[i][11:0];
      #1 chk(mode == 0 ? "R1 pass" : "R9 undefined mode", dout, NRM_VEC[i][11:0]);
    end

    // R2/R3/R4: double-phase table
    mode = 4'd1;
    for (int i = 0; i < 8; i++) begin
      pix_step(PIX_VEC[i][23:12], PIX_VEC[i][11:0]);
      chk("R2 R3 pixel pair", dout, pix_exp(PIX_VEC[i][23:12], PIX_VEC[i][11:0]));
    end

    // R4: toggling unused lines only
    pix_step(12'hF03, 12'h0A8);
    chk("R4 ignored lines", dout, pix_exp(12'h000, 12'h0A8));

    // R6: snapshot in double-phase mode and hold
    snap_rd = 1'b1;
    @(posedge clk); #1 snap_rd = 1'b0;
    chk("R6 snapshot load", snap_q, pix_exp(12'h000, 12'h0A8));
    din = 12'h000;
    repeat (3) @(posedge clk);
    #1 chk("R6 snapshot hold", snap_q, pix_exp(12'h000, 12'h0A8));

    // R7/R8: counted pattern in pass-through mode
    mode = 4'd0;
    for (int n = 0; n <= 40; n++) begin
      @(negedge clk);
      din = pat(n);
      cap_arm = (n == 2);
      snap_rd = (n == 10);
      if (n == 20) chk("R8 not yet done", {11'd0, cap_done}, 12'h000);
    end
    @(negedge clk); cap_arm = 1'b0; snap_rd = 1'b0;
    chk("R7 synced snapshot", snap_q, pat(8));
    chk("R8 done", {11'd0, cap_done}, 12'h001);
    for (int i = 0; i < 32; i++) begin
      cap_raddr = 5'(i);
      #1 chk("R8 entry", cap_rdata, pat(1 + i));
    end

    // R8: re-arm clears done
    @(negedge clk); cap_arm = 1'b1;
    @(negedge clk); cap_arm = 1'b0;
    chk("R8 rearm clears done", {11'd0, cap_done}, 12'h000);

    finish_run();
  end
endmodule